// File: doc/BRIEF.md
# Shared-Opcode ALU Instruction Decoder

This block decodes the arithmetic and logic instructions of a small 16-bit processor with eight registers. Two commutative operations share one opcode. The decoder tells them apart by the relative order of the two source register numbers in the instruction word. When both source fields name the same register, the encoding no longer means a binary operation. A small function field then selects a single-operand operation, or marks the word as illegal.

A second opcode adds a sign-extended 8-bit constant to the destination register in place.

The decoder takes an instruction word with a valid strobe. It returns:
- an operation select;
- the destination and both source register indices;
- a sign-extended immediate with a flag that says it is in use;
- a register write enable;
- an illegal-instruction flag.

By default it is purely combinational, so the results appear in the same cycle as the strobe. A parameter adds one output register, which has a synchronous active-low reset. Software must order the sources of the commutative pair to suit the rule. The decoder never swaps them.

Top module: `opord_alu_decoder`

Instruction layout used throughout (16 bits):

| Bits | Field |
|------|-------|
| [15:12] | opcode |
| [11:9] | destination (rd) |
| [8:6] | first source (rs1) |
| [5:3] | second source (rs2) |
| [2:0] | unary function field (funct) |
| [7:0] | immediate, in the immediate form only |

Opcodes:
- 4'h3: shared add/and opcode.
- 4'h5: add-immediate.

Operation select codes: NOP = 0, ADD = 1, AND = 2, SHL1 = 3 (shift left by one).

## Requirements
- R1: For opcode 4'h3 with rs1 < rs2 and a valid strobe, op_sel is ADD (1), reg_wen is 1, imm_use is 0 and illegal_insn is 0.
- R2: For opcode 4'h3 with rs1 > rs2 and a valid strobe, op_sel is AND (2), reg_wen is 1, imm_use is 0 and illegal_insn is 0.
- R3: For opcode 4'h3 with rs1 == rs2 and funct (bits [2:0]) equal to 0, op_sel is SHL1 (3) and reg_wen is 1.
- R4: For opcode 4'h3 with rs1 == rs2 and a nonzero funct, illegal_insn is 1, reg_wen is 0 and op_sel is NOP (0).
- R5: For every valid opcode-4'h3 word, the outputs copy the fields in encoded order: dst_idx = bits [11:9], src_a_idx = bits [8:6], src_b_idx = bits [5:3]. Sources are never swapped.
- R6: For opcode 4'h5, the outputs are:
  - op_sel is ADD;
  - dst_idx and src_a_idx both equal bits [11:9];
  - src_b_idx is 0;
  - imm_val is bits [7:0] sign-extended to 16 bits;
  - imm_use is 1 and reg_wen is 1.
- R7: With insn_valid low, every output is 0.
- R8: A valid word whose opcode is neither 4'h3 nor 4'h5 yields all outputs 0, with no illegal flag.
- R9: When rs1 differs from rs2, the funct bits have no effect on any output.
- R10: With the default parameters, the outputs follow the inputs in the same cycle. Reset, when asserted, does not change them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous active-low reset |
| insn_valid | input | 1 | Instruction word is valid this cycle |
| insn | input | 16 | Instruction word |
| op_sel | output | 2 | ALU operation: 0 NOP, 1 ADD, 2 AND, 3 SHL1 |
| dst_idx | output | 3 | Destination register index |
| src_a_idx | output | 3 | First operand register index |
| src_b_idx | output | 3 | Second operand register index |
| imm_val | output | 16 | Sign-extended immediate |
| imm_use | output | 1 | Second operand is the immediate |
| reg_wen | output | 1 | Destination register is written |
| illegal_insn | output | 1 | Word is an undefined encoding |

## Verification
Two decisions can land in the same cycle:
- the source-order comparison that picks the operation;
- the function-field check that raises the illegal flag.

Both act when the two source fields are equal. The bench provokes this by sweeping all 64 source pairs of the shared opcode, each with a zero and a nonzero function field. It then judges each word:
- every equal pair with a nonzero field must raise only the illegal flag, with writes suppressed;
- every unequal pair must give the same result whatever the field holds;
- the operands must come out in encoded order in all cases.

// File: rtl/opord_alu_pkg.sv
// Package: shared types for the shared-opcode ALU decoder.
// Assumes a 2-bit operation select that the downstream ALU decodes.
package opord_alu_pkg;

    // ALU operation select codes seen at the op_sel port
    typedef enum logic [1:0] {
        ALU_NOP  = 2'd0,
        ALU_ADD  = 2'd1,
        ALU_AND  = 2'd2,
        ALU_SHL1 = 2'd3
    } alu_op_e;

    // Result of comparing the two source register fields
    typedef enum logic [1:0] {
        ORD_LT = 2'd0,
        ORD_EQ = 2'd1,
        ORD_GT = 2'd2
    } src_order_e;

endpackage

// File: rtl/opord_fields.sv
// Module: opord_fields
// Slices an instruction word into its fixed fields.
// Assumes the layout is opcode | rd | rs1 | rs2 | funct, packed from the MSB.
// The immediate occupies the low IMM_W bits and is sign-extended to XLEN.
module opord_fields #(
    parameter int INSN_W = 16,
    parameter int OPC_W  = 4,
    parameter int RIDX_W = 3,
    parameter int IMM_W  = 8,
    parameter int XLEN   = 16,
    localparam int OPC_LSB = INSN_W - OPC_W,
    localparam int RD_LSB  = OPC_LSB - RIDX_W,
    localparam int RS1_LSB = RD_LSB - RIDX_W,
    localparam int RS2_LSB = RS1_LSB - RIDX_W,
    localparam int FN_W    = RS2_LSB
) (
    input  logic [INSN_W-1:0] insn,
    output logic [OPC_W-1:0]  opcode,
    output logic [RIDX_W-1:0] rd,
    output logic [RIDX_W-1:0] rs1,
    output logic [RIDX_W-1:0] rs2,
    output logic [FN_W-1:0]   funct,
    output logic [XLEN-1:0]   imm_sext
);

    // Field extraction at fixed bit positions
    always_comb begin
        opcode   = insn[OPC_LSB +: OPC_W];
        rd       = insn[RD_LSB  +: RIDX_W];
        rs1      = insn[RS1_LSB +: RIDX_W];
        rs2      = insn[RS2_LSB +: RIDX_W];
        funct    = insn[FN_W-1:0];
        imm_sext = {{(XLEN-IMM_W){insn[IMM_W-1]}}, insn[IMM_W-1:0]};
    end

endmodule

// File: rtl/opord_order_cmp.sv
// Module: opord_order_cmp
// Classifies the two source register numbers as less, equal or greater.
// Assumes unsigned register indices.
module opord_order_cmp
    import opord_alu_pkg::*;
#(
    parameter int RIDX_W = 3
) (
    input  logic [RIDX_W-1:0] rs1,
    input  logic [RIDX_W-1:0] rs2,
    output src_order_e        order
);

    // Three-way unsigned comparison
    always_comb begin
        if (rs1 == rs2)     order = ORD_EQ;
        else if (rs1 > rs2) order = ORD_GT;
        else                order = ORD_LT;
    end

endmodule

// File: rtl/opord_op_select.sv
// Module: opord_op_select
// Chooses the ALU operation and the operand indices from the decoded fields.
// Assumes:
//   - the shared opcode means ADD when rs1 < rs2 and AND when rs1 > rs2;
//   - equal sources select a unary operation through funct, where 0 means SHL1
//     and every other value is illegal;
//   - sources are passed on in encoded order and never swapped.
module opord_op_select
    import opord_alu_pkg::*;
#(
    parameter int OPC_W  = 4,
    parameter int RIDX_W = 3,
    parameter int FN_W   = 3,
    parameter int XLEN   = 16,
    parameter logic [OPC_W-1:0] OPC_SHARED = 4'h3,
    parameter logic [OPC_W-1:0] OPC_ADDI   = 4'h5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid,
    input  logic [OPC_W-1:0]  opcode,
    input  logic [RIDX_W-1:0] rd,
    input  logic [RIDX_W-1:0] rs1,
    input  logic [RIDX_W-1:0] rs2,
    input  logic [FN_W-1:0]   funct,
    input  logic [XLEN-1:0]   imm_sext,
    input  src_order_e        order,
    output alu_op_e           op,
    output logic [RIDX_W-1:0] dst,
    output logic [RIDX_W-1:0] src_a,
    output logic [RIDX_W-1:0] src_b,
    output logic [XLEN-1:0]   imm,
    output logic              use_imm,
    output logic              wen,
    output logic              illegal
);

    // Operation and operand selection; every output is quiet unless an ALU word is valid
    always_comb begin
        op      = ALU_NOP;
        dst     = '0;
        src_a   = '0;
        src_b   = '0;
        imm     = '0;
        use_imm = 1'b0;
        wen     = 1'b0;
        illegal = 1'b0;
        if (valid && opcode == OPC_SHARED) begin
            dst   = rd;
            src_a = rs1;
            src_b = rs2;
            unique case (order)
                ORD_LT: begin
                    op  = ALU_ADD;
                    wen = 1'b1;
                end
                ORD_GT: begin
                    op  = ALU_AND;
                    wen = 1'b1;
                end
                default: begin
                    if (funct == '0) begin
                        op  = ALU_SHL1;
                        wen = 1'b1;
                    end else begin
                        illegal = 1'b1;
                    end
                end
            endcase
        end else if (valid && opcode == OPC_ADDI) begin
            op      = ALU_ADD;
            dst     = rd;
            src_a   = rd;
            imm     = imm_sext;
            use_imm = 1'b1;
            wen     = 1'b1;
        end
    end

    AST_ADD_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (op == ALU_ADD && !use_imm) |-> (src_a < src_b)) else $error("add order"); // R1
    AST_AND_DESCENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (op == ALU_AND) |-> (src_a > src_b)) else $error("and order"); // R2
    AST_SHL_SAME_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        (op == ALU_SHL1) |-> (src_a == src_b && wen)) else $error("shl sources"); // R3
    AST_ILLEGAL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!wen && op == ALU_NOP)) else $error("illegal writes"); // R4
    AST_IMM_IN_PLACE: assert property (@(posedge clk) disable iff (!rst_n)
        use_imm |-> (src_a == dst && src_b == '0 && wen)) else $error("imm form"); // R6

endmodule

// File: rtl/opord_out_stage.sv
// Module: opord_out_stage
// Passes the decoded bundle through unchanged, or holds it in one register.
// Assumes the register, when present, has a synchronous active-low reset that clears it.
module opord_out_stage #(
    parameter int DW     = 8,
    parameter bit REG_EN = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] d,
    output logic [DW-1:0] q
);

    generate
        if (REG_EN) begin : g_reg
            logic [DW-1:0] q_r;

            // Registered copy of the decoded bundle
            always_ff @(posedge clk) begin
                if (!rst_n) q_r <= '0;
                else        q_r <= d;
            end

            assign q = q_r;
        end else begin : g_comb
            assign q = d;
        end
    endgenerate

endmodule

// File: rtl/opord_alu_decoder.sv
// Module: opord_alu_decoder (top)
// Decodes the shared add/and opcode and the add-immediate opcode.
// Assumes an instruction layout of opcode[15:12] rd[11:9] rs1[8:6] rs2[5:3] funct[2:0],
// with the immediate in [7:0]. The result is combinational unless OUT_REG is set.
module opord_alu_decoder
    import opord_alu_pkg::*;
#(
    parameter int INSN_W = 16,
    parameter int OPC_W  = 4,
    parameter int RIDX_W = 3,
    parameter int IMM_W  = 8,
    parameter int XLEN   = 16,
    parameter logic [OPC_W-1:0] OPC_SHARED = 4'h3,
    parameter logic [OPC_W-1:0] OPC_ADDI   = 4'h5,
    parameter bit OUT_REG = 1'b0,
    localparam int FN_W = INSN_W - OPC_W - 3 * RIDX_W,
    localparam int BW   = 2 + 3 * RIDX_W + XLEN + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              insn_valid,
    input  logic [INSN_W-1:0] insn,
    output logic [1:0]        op_sel,
    output logic [RIDX_W-1:0] dst_idx,
    output logic [RIDX_W-1:0] src_a_idx,
    output logic [RIDX_W-1:0] src_b_idx,
    output logic [XLEN-1:0]   imm_val,
    output logic              imm_use,
    output logic              reg_wen,
    output logic              illegal_insn
);

    logic [OPC_W-1:0]  f_opc;
    logic [RIDX_W-1:0] f_rd, f_rs1, f_rs2;
    logic [FN_W-1:0]   f_fn;
    logic [XLEN-1:0]   f_imm;
    src_order_e        ord;
    alu_op_e           s_op;
    logic [RIDX_W-1:0] s_dst, s_a, s_b;
    logic [XLEN-1:0]   s_imm;
    logic              s_use, s_wen, s_ill;
    logic [BW-1:0]     bundle_d, bundle_q;

    opord_fields #(
        .INSN_W(INSN_W), .OPC_W(OPC_W), .RIDX_W(RIDX_W), .IMM_W(IMM_W), .XLEN(XLEN)
    ) fields_i (
        .insn(insn), .opcode(f_opc), .rd(f_rd), .rs1(f_rs1), .rs2(f_rs2),
        .funct(f_fn), .imm_sext(f_imm)
    );

    opord_order_cmp #(.RIDX_W(RIDX_W)) cmp_i (
        .rs1(f_rs1), .rs2(f_rs2), .order(ord)
    );

    opord_op_select #(
        .OPC_W(OPC_W), .RIDX_W(RIDX_W), .FN_W(FN_W), .XLEN(XLEN),
        .OPC_SHARED(OPC_SHARED), .OPC_ADDI(OPC_ADDI)
    ) sel_i (
        .clk(clk), .rst_n(rst_n), .valid(insn_valid), .opcode(f_opc), .rd(f_rd),
        .rs1(f_rs1), .rs2(f_rs2), .funct(f_fn), .imm_sext(f_imm), .order(ord),
        .op(s_op), .dst(s_dst), .src_a(s_a), .src_b(s_b), .imm(s_imm),
        .use_imm(s_use), .wen(s_wen), .illegal(s_ill)
    );

    // Pack the decoded result for the output stage
    always_comb begin
        bundle_d = {s_op, s_dst, s_a, s_b, s_imm, s_use, s_wen, s_ill};
    end

    opord_out_stage #(.DW(BW), .REG_EN(OUT_REG)) out_i (
        .clk(clk), .rst_n(rst_n), .d(bundle_d), .q(bundle_q)
    );

    // Unpack onto the ports
    always_comb begin
        {op_sel, dst_idx, src_a_idx, src_b_idx, imm_val, imm_use, reg_wen, illegal_insn} = bundle_q;
    end

    generate
        if (!OUT_REG) begin : g_comb_checks
            AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
                !insn_valid |-> (!reg_wen && !illegal_insn && op_sel == 2'd0)) else $error("idle"); // R7
            AST_ENCODED_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
                (insn_valid && insn[INSN_W-1 -: OPC_W] == OPC_SHARED) |->
                (src_a_idx == insn[INSN_W-OPC_W-RIDX_W-1 -: RIDX_W] &&
                 src_b_idx == insn[INSN_W-OPC_W-2*RIDX_W-1 -: RIDX_W])) else $error("order"); // R5
        end
    endgenerate

endmodule

// File: tb/opord_alu_decoder_tb.sv
module opord_alu_decoder_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        insn_valid = 1'b0;
    logic [15:0] insn = '0;
    logic [1:0]  op_sel;
    logic [2:0]  dst_idx, src_a_idx, src_b_idx;
    logic [15:0] imm_val;
    logic        imm_use, reg_wen, illegal_insn;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    opord_alu_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn(insn),
        .op_sel(op_sel), .dst_idx(dst_idx), .src_a_idx(src_a_idx), .src_b_idx(src_b_idx),
        .imm_val(imm_val), .imm_use(imm_use), .reg_wen(reg_wen), .illegal_insn(illegal_insn)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive at the falling edge and sample 1 ns later (combinational path)
    task automatic apply(input logic v, input logic [15:0] w);
        @(negedge clk);
        insn_valid = v;
        insn = w;
        #1;
    endtask

    function automatic logic [15:0] enc(input logic [3:0] opc, input logic [2:0] rd,
                                        input logic [2:0] a, input logic [2:0] b,
                                        input logic [2:0] fn);
        return {opc, rd, a, b, fn};
    endfunction

    function automatic logic [31:0] bundle();
        return {7'd0, op_sel, dst_idx, src_a_idx, src_b_idx, imm_val, imm_use, reg_wen, illegal_insn};
    endfunction

    task automatic t_reset();
        apply(1'b0, 16'hFFFF);
        chk("R7 reset idle", bundle(), 32'd0);
        // R10: reset asserted while a valid word is present does not change the result
        apply(1'b1, enc(4'h3, 3'd2, 3'd1, 3'd4, 3'd0));
        chk("R10 same-cycle under reset", {30'd0, op_sel}, 32'd1);
        chk("R10 wen under reset", {31'd0, reg_wen}, 32'd1);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // R1 R2 R3 R4 R5 sweep of all source pairs, funct 0 and funct nonzero
    task automatic t_sweep();
        for (int fz = 0; fz < 2; fz++) begin
            for (int a = 0; a < 8; a++) begin
                for (int b = 0; b < 8; b++) begin
                    logic [2:0] rd = 3'(a ^ b ^ 5);
                    logic [2:0] fn = (fz == 0) ? 3'd0 : 3'(1 + ((a + b) % 7));
                    logic [1:0] e_op;
                    logic e_wen, e_ill;
                    apply(1'b1, enc(4'h3, rd, 3'(a), 3'(b), fn));
                    if (a < b) begin e_op = 2'd1; e_wen = 1; e_ill = 0; end
                    else if (a > b) begin e_op = 2'd2; e_wen = 1; e_ill = 0; end
                    else if (fn == 0) begin e_op = 2'd3; e_wen = 1; e_ill = 0; end
                    else begin e_op = 2'd0; e_wen = 0; e_ill = 1; end
                    if (a < b) chk("R1 add op", {30'd0, op_sel}, {30'd0, e_op});
                    else if (a > b) chk("R2 and op", {30'd0, op_sel}, {30'd0, e_op});
                    else if (fn == 0) chk("R3 shl op", {30'd0, op_sel}, {30'd0, e_op});
                    else chk("R4 illegal op", {30'd0, op_sel}, {30'd0, e_op});
                    chk("R4 wen/illegal", {30'd0, reg_wen, illegal_insn}, {30'd0, e_wen, e_ill});
                    chk("R5 encoded order", {23'd0, dst_idx, src_a_idx, src_b_idx},
                        {23'd0, rd, 3'(a), 3'(b)});
                    chk("R1 no imm", {31'd0, imm_use}, 32'd0);
                end
            end
        end
    endtask

    // R9: with unequal sources, every funct value gives the same outputs
    task automatic t_funct_ignored();
        logic [31:0] ref_b;
        apply(1'b1, enc(4'h3, 3'd6, 3'd5, 3'd2, 3'd0));
        ref_b = bundle();
        for (int f = 1; f < 8; f++) begin
            apply(1'b1, enc(4'h3, 3'd6, 3'd5, 3'd2, 3'(f)));
            chk("R9 funct ignored", bundle(), ref_b);
        end
    endtask

    // R6 add-immediate with positive and negative constants
    task automatic t_addi();
        apply(1'b1, {4'h5, 3'd3, 1'b1, 8'h7F});
        chk("R6 addi positive", bundle(),
            {7'd0, 2'd1, 3'd3, 3'd3, 3'd0, 16'h007F, 1'b1, 1'b1, 1'b0});
        apply(1'b1, {4'h5, 3'd7, 1'b0, 8'h80});
        chk("R6 addi negative", bundle(),
            {7'd0, 2'd1, 3'd7, 3'd7, 3'd0, 16'hFF80, 1'b1, 1'b1, 1'b0});
    endtask

    // R7 invalid strobe, R8 foreign opcodes
    task automatic t_quiet();
        apply(1'b0, enc(4'h3, 3'd1, 3'd1, 3'd1, 3'd4));
        chk("R7 invalid illegal-pattern", bundle(), 32'd0);
        apply(1'b0, {4'h5, 3'd2, 1'b0, 8'h11});
        chk("R7 invalid addi", bundle(), 32'd0);
        for (int o = 0; o < 16; o++) begin
            if (o != 3 && o != 5) begin
                apply(1'b1, enc(4'(o), 3'd4, 3'd3, 3'd3, 3'd6));
                chk("R8 foreign opcode", bundle(), 32'd0);
            end
        end
    endtask

    initial begin
        t_reset();
        t_sweep();
        t_funct_ignored();
        t_addi();
        t_quiet();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule